// File: doc/BRIEF.md
# PHY Control Register Bank with Set/Clear/Toggle Aliases

This block holds the 32-bit configuration and status words of a USB PHY control block behind a simple word-addressed bus: byte address, write enable, write data, read enable and registered read data. A 4 KiB window is decoded, and the word index is the byte address shifted right by two. Each modifiable register owns a group of four consecutive words. The first is the register itself. The next three are write aliases that OR, AND-NOT or XOR the bus data into it, so software can change single bits without a read-modify-write.

Bit 31 of the control register requests a soft reset. The request fires from a direct write or a set-alias write whose data has bit 31 high. It also fires from a toggle-alias write whose data has bit 31 high, but only if bit 31 is 1 after the toggle. A clear-alias write never fires it. A soft reset reloads the power-down, transmit, receive and control registers, and the reloaded values win over the data that was just written. The status, debug and debug1 registers keep their contents. The asynchronous hardware reset loads every register.

Word map, as word indices: power-down group 0–3, transmit 4–7, receive 8–11, control 12–15, status 16, debug 20–23, debug0-status 24, debug1 28–31, version 32. Within a group, offset +0 is the register, +1 the set alias, +2 the clear alias and +3 the toggle alias. Every other word index is unmapped.

Top module: `phy_regs_bank`

## Requirements
- R1: Hardware reset loads power-down 0x001E1C00, transmit 0x10060607, receive 0, control 0xC0200000, status 0, debug 0x7F180000, debug0-status 0, debug1 0x00001000 and version 0x04020000. It also clears rdata_o to 0.
- R2: A write to the +0 word of power-down, transmit, receive, control, status, debug or debug1 stores the data unchanged (for control only when data bit 31 is 0).
- R3: A write to a set alias (+1) ORs the data into its register.
- R4: A write to a clear alias (+2) ANDs its register with the inverted data.
- R5: A write to a toggle alias (+3) XORs the data into its register.
- R6: A read of any +1, +2 or +3 alias returns the current value of its register.
- R7: Writes to version (word 32) and debug0-status (word 24) are ignored. Words 17–19 are unmapped: writing them leaves status unchanged, and reading them returns 0.
- R8: A direct or set-alias write to control whose data has bit 31 high reloads power-down, transmit, receive and control with their reset values from R1. These reloaded values take priority over the written data. A direct write with bit 31 low triggers nothing.
- R9: A toggle-alias write to control triggers the reload of R8 only when data bit 31 is high and control bit 31 is 1 after the toggle. A clear-alias write to control never triggers it.
- R10: The soft reset leaves status, debug and debug1 unchanged.
- R11: Read data appears on rdata_o one cycle after read enable and holds while read enable is low. A read and a write to the same word in one cycle return the value from before the write.
- R12: Unmapped words inside the window read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address within the 4 KiB window; bits [1:0] are not decoded |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Registered read data |

## Verification
The properties assume that every access is a whole aligned word with addr_i[1:0] at zero, and that reset is asserted from time zero. The assumed pairing of one address and one data word per cycle holds by construction: the bus is single-ported. The stimulus changes inputs only on the falling clock edge. It uses aligned byte addresses only, and holds write and read enable low between accesses. The one exception is the deliberate same-cycle read-and-write case. Soft-reset properties key on the address and data at the bus pins, so the stimulus reaches control only through its four group words.

// File: rtl/phy_regs_pkg.sv
`timescale 1ns/1ps
package phy_regs_pkg;

  localparam int DW   = 32;
  localparam int AW   = 12;
  localparam int IW   = AW - 2;
  localparam int NREG = 9;
  localparam int GW   = IW - 2;
  localparam int SRST_BIT = 31;

  typedef enum logic [1:0] {
    OP_BASE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TOG  = 2'd3
  } alias_op_e;

  // group index of each register; word index = {group, op}
  typedef enum logic [3:0] {
    RG_PWR  = 4'd0,
    RG_TX   = 4'd1,
    RG_RX   = 4'd2,
    RG_CTRL = 4'd3,
    RG_STAT = 4'd4,
    RG_DBG  = 4'd5,
    RG_DBG0 = 4'd6,
    RG_DBG1 = 4'd7,
    RG_VER  = 4'd8
  } reg_id_e;

  localparam logic [DW-1:0] PWR_DEF  = 32'h001E_1C00;
  localparam logic [DW-1:0] TX_DEF   = 32'h1006_0607;
  localparam logic [DW-1:0] RX_DEF   = 32'h0000_0000;
  localparam logic [DW-1:0] CTRL_DEF = 32'hC020_0000;
  localparam logic [DW-1:0] STAT_DEF = 32'h0000_0000;
  localparam logic [DW-1:0] DBG_DEF  = 32'h7F18_0000;
  localparam logic [DW-1:0] DBG0_DEF = 32'h0000_0000;
  localparam logic [DW-1:0] DBG1_DEF = 32'h0000_1000;
  localparam logic [DW-1:0] VER_DEF  = 32'h0402_0000;

  function automatic logic [DW-1:0] reg_default(int i);
    case (i)
      0: return PWR_DEF;
      1: return TX_DEF;
      2: return RX_DEF;
      3: return CTRL_DEF;
      4: return STAT_DEF;
      5: return DBG_DEF;
      6: return DBG0_DEF;
      7: return DBG1_DEF;
      default: return VER_DEF;
    endcase
  endfunction

  function automatic bit reg_has_alias(int i);
    return (i <= 3) || (i == 5) || (i == 7);
  endfunction

  function automatic bit reg_writable(int i);
    return (i != 6) && (i != 8) && (i < NREG);
  endfunction

  function automatic bit reg_soft_member(int i);
    return (i <= 3);
  endfunction

  function automatic logic [IW-1:0] word_idx(reg_id_e r, alias_op_e op);
    return {{(GW-4){1'b0}}, r, op};
  endfunction

endpackage

// File: rtl/phy_regs_decode.sv
`timescale 1ns/1ps
module phy_regs_decode
  import phy_regs_pkg::*;
#(
  parameter int IDX_W = IW
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [3:0]       reg_o,
  output alias_op_e        op_o,
  output logic             rd_hit_o,
  output logic             wr_hit_o
);

  localparam int GRP_W = IDX_W - 2;

  logic [GRP_W-1:0] grp;
  logic             in_range;
  logic             alias_ok;

  assign grp      = idx_i[IDX_W-1:2];
  assign op_o     = alias_op_e'(idx_i[1:0]);
  assign in_range = (grp < GRP_W'(NREG));
  assign reg_o    = in_range ? grp[3:0] : 4'd0;

  always_comb begin
    alias_ok = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (grp[3:0] == 4'(i))
        alias_ok = reg_has_alias(i) || (op_o == OP_BASE);
    end
  end

  always_comb begin
    wr_hit_o = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (grp[3:0] == 4'(i))
        wr_hit_o = reg_writable(i);
    end
    wr_hit_o = wr_hit_o && in_range && alias_ok;
  end

  assign rd_hit_o = in_range && alias_ok;

endmodule

// File: rtl/phy_regs_cell.sv
`timescale 1ns/1ps
module phy_regs_cell
  import phy_regs_pkg::*;
#(
  parameter int            W           = DW,
  parameter logic [W-1:0]  RST_VAL     = '0,
  parameter bit            SOFT_MEMBER = 1'b0,
  parameter bit            HAS_ALIAS   = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  alias_op_e    op_i,
  input  logic [W-1:0] wdata_i,
  input  logic         srst_i,
  output logic [W-1:0] nxt_o,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;
  logic         soft_hit;

  generate
    if (HAS_ALIAS) begin : g_alias
      always_comb begin
        unique case (op_i)
          OP_BASE: nxt_o = wdata_i;
          OP_SET:  nxt_o = q | wdata_i;
          OP_CLR:  nxt_o = q & ~wdata_i;
          OP_TOG:  nxt_o = q ^ wdata_i;
        endcase
      end
    end else begin : g_plain
      logic unused_op;
      assign unused_op = ^op_i;
      assign nxt_o     = wdata_i;
    end

    if (SOFT_MEMBER) begin : g_soft
      assign soft_hit = srst_i;
    end else begin : g_nosoft
      logic unused_srst;
      assign unused_srst = srst_i;
      assign soft_hit    = 1'b0;
    end
  endgenerate

  // soft-reset defaults win over the write of the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= RST_VAL;
    else if (soft_hit) q <= RST_VAL;
    else if (wr_i)     q <= nxt_o;
  end

  assign q_o = q;

endmodule

// File: rtl/phy_regs_rdmux.sv
`timescale 1ns/1ps
module phy_regs_rdmux
  import phy_regs_pkg::*;
#(
  parameter int W = DW,
  parameter int N = NREG
) (
  input  logic [W-1:0] regs_i [N],
  input  logic [3:0]   sel_i,
  input  logic         hit_i,
  output logic [W-1:0] data_o
);

  always_comb begin
    data_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_i && sel_i == 4'(i)) data_o = regs_i[i];
    end
  end

endmodule

// File: rtl/phy_regs_bank.sv
`timescale 1ns/1ps
module phy_regs_bank
  import phy_regs_pkg::*;
#(
  parameter int ADDR_W = AW,
  parameter int DATA_W = DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic [3:0]        sel;
  alias_op_e         op;
  logic              rd_hit;
  logic              wr_hit;
  logic [DATA_W-1:0] reg_q  [NREG];
  logic [DATA_W-1:0] nxt_w  [NREG];
  logic [NREG-1:0]   reg_wr;
  logic              srst;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_addr;
  logic              unused_nxt;

  assign idx         = addr_i[ADDR_W-1:2];
  assign unused_addr = ^addr_i[1:0];

  phy_regs_decode #(.IDX_W(IDX_W)) u_dec (
    .idx_i    (idx),
    .reg_o    (sel),
    .op_o     (op),
    .rd_hit_o (rd_hit),
    .wr_hit_o (wr_hit)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign reg_wr[g] = we_i && wr_hit && (sel == 4'(g));

    phy_regs_cell #(
      .W           (DATA_W),
      .RST_VAL     (DATA_W'(reg_default(g))),
      .SOFT_MEMBER (reg_soft_member(g)),
      .HAS_ALIAS   (reg_has_alias(g))
    ) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (reg_wr[g]),
      .op_i    (op),
      .wdata_i (wdata_i),
      .srst_i  (srst),
      .nxt_o   (nxt_w[g]),
      .q_o     (reg_q[g])
    );
  end

  always_comb begin
    unused_nxt = 1'b0;
    for (int i = 0; i < NREG; i++) unused_nxt = unused_nxt ^ (^nxt_w[i]);
  end

  // data bit high and bit high after the op: covers direct/set, gates toggle,
  // and can never hold for clear
  assign srst = reg_wr[RG_CTRL] && wdata_i[SRST_BIT] && nxt_w[RG_CTRL][SRST_BIT];

  phy_regs_rdmux #(.W(DATA_W), .N(NREG)) u_rdmux (
    .regs_i (reg_q),
    .sel_i  (sel),
    .hit_i  (rd_hit),
    .data_o (rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/phy_regs_bank_chk.sv
`timescale 1ns/1ps
module phy_regs_bank_chk
  import phy_regs_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          we_i,
  input logic [DW-1:0] wdata_i,
  input logic          re_i,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] pwr_q,
  input logic [DW-1:0] tx_q,
  input logic [DW-1:0] rx_q,
  input logic [DW-1:0] ctrl_q,
  input logic [DW-1:0] dbg_q
);

  logic [IW-1:0] idx;
  assign idx = addr_i[AW-1:2];

  AST_SET_ORS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == word_idx(RG_TX, OP_SET)) |=> tx_q == ($past(tx_q) | $past(wdata_i))); // R3

  AST_CLR_ANDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == word_idx(RG_RX, OP_CLR)) |=> rx_q == ($past(rx_q) & ~$past(wdata_i))); // R4

  AST_TOG_XORS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == word_idx(RG_DBG, OP_TOG)) |=> dbg_q == ($past(dbg_q) ^ $past(wdata_i))); // R5

  AST_SOFT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx == word_idx(RG_CTRL, OP_BASE) && wdata_i[SRST_BIT])
    |=> (ctrl_q == CTRL_DEF && pwr_q == PWR_DEF && tx_q == TX_DEF && rx_q == RX_DEF)); // R8

  AST_VER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && idx == word_idx(RG_VER, OP_BASE)) |=> rdata_o == VER_DEF); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i[AW-1:8] != '0) |=> rdata_o == '0); // R12

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o)); // R11

endmodule

bind phy_regs_bank phy_regs_bank_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .re_i    (re_i),
  .rdata_o (rdata_o),
  .pwr_q   (reg_q[0]),
  .tx_q    (reg_q[1]),
  .rx_q    (reg_q[2]),
  .ctrl_q  (reg_q[3]),
  .dbg_q   (reg_q[5])
);

// File: tb/phy_regs_bank_bench.sv
`timescale 1ns/1ps
module phy_regs_bank_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [11:0] addr_i;
  logic        we_i;
  logic [31:0] wdata_i;
  logic        re_i;
  logic [31:0] rdata_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  logic rd_flag;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk_i = ~clk_i;

  phy_regs_bank u_phy_regs_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .re_i    (re_i),
    .rdata_o (rdata_o)
  );

  // monitor
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_flag <= 1'b0;
    else         rd_flag <= re_i;
  end

  always @(negedge clk_i) begin
    if (rd_flag && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (rdata_o !== e) begin
        n_fails++;
        $display("FAIL %s: rdata actual %08h expected %08h", t, rdata_o, e);
      end
    end
  end

  // driver
  task automatic access(bit we, bit re, logic [11:0] a, logic [31:0] d,
                        logic [31:0] exp, string tag);
    @(negedge clk_i);
    we_i = we; re_i = re; addr_i = a; wdata_i = d;
    if (re) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(negedge clk_i);
    we_i = 1'b0; re_i = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    access(1'b1, 1'b0, a, d, 32'h0, "");
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    access(1'b0, 1'b1, a, 32'h0, exp, tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    rst_ni = 1'b0; we_i = 1'b0; re_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    n_checks++;
    if (rdata_o !== 32'h0) begin
      n_fails++;
      $display("FAIL R1: rdata in reset actual %08h expected %08h", rdata_o, 32'h0);
    end
    rst_ni = 1'b1;

    // R1 reset values
    rd(12'h000, 32'h001E1C00, "R1 pwr");
    rd(12'h010, 32'h10060607, "R1 tx");
    rd(12'h020, 32'h00000000, "R1 rx");
    rd(12'h030, 32'hC0200000, "R1 ctrl");
    rd(12'h040, 32'h00000000, "R1 stat");
    rd(12'h050, 32'h7F180000, "R1 dbg");
    rd(12'h060, 32'h00000000, "R1 dbg0");
    rd(12'h070, 32'h00001000, "R1 dbg1");
    rd(12'h080, 32'h04020000, "R1 ver");

    // R2 direct writes
    wr(12'h010, 32'h12345678);
    rd(12'h010, 32'h12345678, "R2 tx");
    wr(12'h040, 32'hA5A5A5A5);
    rd(12'h040, 32'hA5A5A5A5, "R2 stat");

    // R3..R6 aliases
    wr(12'h014, 32'h0000FF00);
    rd(12'h010, 32'h1234FF78, "R3 tx set");
    rd(12'h014, 32'h1234FF78, "R6 tx set alias read");
    wr(12'h018, 32'h12000000);
    rd(12'h010, 32'h0034FF78, "R4 tx clr");
    rd(12'h018, 32'h0034FF78, "R6 tx clr alias read");
    wr(12'h01C, 32'hFFFF0000);
    rd(12'h010, 32'hFFCBFF78, "R5 tx tog");
    rd(12'h01C, 32'hFFCBFF78, "R6 tx tog alias read");
    wr(12'h074, 32'h0000000F);
    rd(12'h070, 32'h0000100F, "R3 dbg1 set");
    wr(12'h058, 32'h7F000000);
    rd(12'h050, 32'h00180000, "R4 dbg clr");
    wr(12'h05C, 32'h00000003);
    rd(12'h050, 32'h00180003, "R5 dbg tog");
    wr(12'h02C, 32'h0000F00F);
    rd(12'h028, 32'h0000F00F, "R5 rx tog via clr alias read R6");

    // R7 read-only and missing aliases
    wr(12'h080, 32'hFFFFFFFF);
    rd(12'h080, 32'h04020000, "R7 ver");
    wr(12'h060, 32'hFFFFFFFF);
    rd(12'h060, 32'h00000000, "R7 dbg0");
    wr(12'h044, 32'hFFFFFFFF);
    rd(12'h040, 32'hA5A5A5A5, "R7 stat after alias-word write");
    rd(12'h044, 32'h00000000, "R7 stat alias word");

    // R12 unmapped
    wr(12'h200, 32'hCAFEF00D);
    rd(12'h200, 32'h00000000, "R12 unmapped");
    rd(12'hFFC, 32'h00000000, "R12 window top");
    rd(12'h0A0, 32'h00000000, "R12 gap");

    // R8 / R10 soft reset by direct write
    wr(12'h000, 32'h00000000);
    wr(12'h020, 32'hDEAD0000);
    wr(12'h030, 32'h80000001);
    rd(12'h030, 32'hC0200000, "R8 ctrl");
    rd(12'h000, 32'h001E1C00, "R8 pwr");
    rd(12'h010, 32'h10060607, "R8 tx");
    rd(12'h020, 32'h00000000, "R8 rx");
    rd(12'h040, 32'hA5A5A5A5, "R10 stat");
    rd(12'h050, 32'h00180003, "R10 dbg");
    rd(12'h070, 32'h0000100F, "R10 dbg1");

    // R2 / R8 control without and with set alias
    wr(12'h010, 32'h00000000);
    wr(12'h030, 32'h00000003);
    rd(12'h030, 32'h00000003, "R2 ctrl no trigger");
    rd(12'h010, 32'h00000000, "R8 tx untouched when bit low");
    wr(12'h034, 32'h80000000);
    rd(12'h030, 32'hC0200000, "R8 ctrl set trigger");
    rd(12'h010, 32'h10060607, "R8 tx reload on set");

    // R9 toggle and clear paths
    wr(12'h010, 32'h11111111);
    wr(12'h03C, 32'h80000000);
    rd(12'h030, 32'h40200000, "R9 toggle to zero");
    rd(12'h010, 32'h11111111, "R9 no reload when bit ends low");
    wr(12'h03C, 32'h80000001);
    rd(12'h030, 32'hC0200000, "R9 toggle to one");
    rd(12'h010, 32'h10060607, "R9 reload when bit ends high");
    wr(12'h010, 32'h22222222);
    wr(12'h038, 32'h80000000);
    rd(12'h030, 32'h40200000, "R9 clear no trigger");
    rd(12'h010, 32'h22222222, "R9 tx kept on clear");

    // R11 latency, ordering and hold
    access(1'b1, 1'b1, 12'h020, 32'h00000055, 32'h00000000, "R11 read before same-cycle write");
    rd(12'h020, 32'h00000055, "R11 value after write");
    repeat (3) @(negedge clk_i);
    n_checks++;
    if (rdata_o !== 32'h00000055) begin
      n_fails++;
      $display("FAIL R11: hold actual %08h expected %08h", rdata_o, 32'h00000055);
    end

    repeat (2) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      n_checks++;
      n_fails++;
      $display("FAIL R11: %0d reads unanswered actual %0d expected 0", exp_q.size(), exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end

endmodule